// File: doc/BRIEF.md
# DMA Bus Master Transfer Sequencer

This block moves a block of 16-bit words between system memory and a small local word buffer, acting as master on a multiplexed address/data backplane bus. Software-side logic hands it a start pulse together with a direction, a 22-bit starting byte address and a word count. For every word the block raises a DMA request and waits for the grant. It then acknowledges the selection and drives the address on the 16 shared lines and the 6 extended lines. After that it runs either a memory-read or a memory-write handshake with the addressed slave. Each word ends with a one-cycle clear step that releases the bus.

The sequence is a fixed hardware state machine, so the bus is held only for the few cycles a word actually needs. A memory read walks through six states (request, acknowledge, address, sync, read-wait, clear). A memory write walks through seven, with a data-present state placed ahead of the write strobe. The local buffer has eight slots. Word k of a transfer uses slot k mod 8, so several words can be waiting in the buffer while grants arrive late. If a slave does not reply within a timeout, the block flags a bus error and abandons the transfer.

Top module: `dma_bus_master`

## Requirements
- R1: While reset is held and after its release, with no start, bus_req, bus_gack, bus_sync, bus_rd, bus_wr, ad_oe, busy and bus_err are all low.
- R2: A start (go high for one cycle) is accepted only when the block is idle and go_words is nonzero; busy is high from the cycle after acceptance. A start with a zero count, or a start while busy, has no effect on the transfer, the addresses or busy.
- R3: bus_req stays high until bus_grant is seen at a clock edge; in the next cycle bus_req is low and bus_gack is high. bus_gack stays high up to the clear step.
- R4: The word address is driven for two cycles, bits 15:0 on ad_out and bits 21:16 on ext_addr, with ad_oe high. bus_sync rises in the second of these cycles and stays high until the clear step.
- R5: On a memory read (go_write=0), bus_rd is held until bus_reply is sampled high. The ad_in value of that cycle is stored into buffer slot (word index mod 8), and bus_rd is high for exactly one cycle more than the reply delay.
- R6: On a memory write (go_write=1), the word from buffer slot (word index mod 8) is driven on ad_out with ad_oe high, one cycle before bus_wr rises. Both are then held until bus_reply is sampled.
- R7: Every word ends with a clear cycle in which bus_req, bus_gack, bus_sync, bus_rd, bus_wr and ad_oe are all low.
- R8: Word k of a transfer uses address base + 2k (modulo 2^22, carrying from bit 15 into the extended lines). xfer_done pulses once, in the clear cycle of the last word. Exactly go_words words are moved, and bus_req is not raised again afterwards.
- R9: If bus_reply is absent for TIMEOUT_CYC consecutive strobe cycles, the strobe is dropped, bus_err goes high, the clear step runs and the block returns to idle with no further request and no xfer_done. bus_err stays high until the next accepted start clears it.
- R10: bus_rd and bus_wr are never high together, and neither is high without bus_sync.
- R11: The local port writes any slot (lb_we, lb_widx, lb_wdata) on a clock edge and reads any slot combinationally (lb_ridx to lb_rdata).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse |
| go_write | input | 1 | 1 = buffer to memory (write), 0 = memory to buffer (read) |
| go_addr | input | 22 | Starting byte address (even) |
| go_words | input | CNT_W | Number of words to move |
| busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle pulse in the last word's clear cycle |
| bus_err | output | 1 | Reply timeout flag, held until next start |
| bus_req | output | 1 | DMA bus request |
| bus_grant | input | 1 | DMA bus grant |
| bus_gack | output | 1 | Selection acknowledge |
| bus_sync | output | 1 | Bus cycle framing strobe |
| bus_rd | output | 1 | Read data strobe |
| bus_wr | output | 1 | Write data strobe |
| bus_reply | input | 1 | Slave reply |
| ad_out | output | 16 | Multiplexed address/data out |
| ad_oe | output | 1 | Drive enable for ad_out and ext_addr |
| ad_in | input | 16 | Multiplexed data in |
| ext_addr | output | 6 | Address bits 21:16 |
| lb_we | input | 1 | Local buffer write enable |
| lb_widx | input | $clog2(BUF_DEPTH) | Local buffer write slot |
| lb_wdata | input | 16 | Local buffer write data |
| lb_ridx | input | $clog2(BUF_DEPTH) | Local buffer read slot |
| lb_rdata | output | 16 | Local buffer read data |

## Verification
The bench builds the block with CNT_W=5, the default eight-slot buffer and TIMEOUT_CYC=12. With a timeout that short, a dead slave runs into the error path within a few cycles, and the exact strobe length of the timeout can be compared against the parameter. The bench sweeps every grant latency from 0 to 2 against every reply delay from 0 to 3 in both directions. Transfers of 9 and 10 words wrap the buffer slots, and base addresses just below 0x10000 and at the top of the 22-bit space bring the carry into the extended lines and the address wrap within reach.

// File: rtl/dmam_pkg.sv
`timescale 1ns/1ps
package dmam_pkg;
  localparam int AD_W   = 16;
  localparam int ADDR_W = 22;
  localparam int EXT_W  = ADDR_W - AD_W;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_REQ    = 4'd1,
    ST_GACK   = 4'd2,
    ST_ADDR   = 4'd3,
    ST_SYNC   = 4'd4,
    ST_RDWAIT = 4'd5,
    ST_WDATA  = 4'd6,
    ST_WSTB   = 4'd7,
    ST_CLR    = 4'd8
  } seq_st_t;

  // byte address of the following 16-bit word
  function automatic logic [ADDR_W-1:0] next_word_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(2);
  endfunction

  // word index modulo the buffer depth
  function automatic int unsigned next_slot(input int unsigned s, input int unsigned depth);
    return (s + 1 >= depth) ? 0 : s + 1;
  endfunction

  function automatic logic waits_reply(input seq_st_t s);
    return (s == ST_RDWAIT) || (s == ST_WSTB);
  endfunction

  function automatic logic holds_ack(input seq_st_t s);
    return (s == ST_GACK) || (s == ST_ADDR) || (s == ST_SYNC) ||
           (s == ST_RDWAIT) || (s == ST_WDATA) || (s == ST_WSTB);
  endfunction

  function automatic logic holds_sync(input seq_st_t s);
    return (s == ST_SYNC) || (s == ST_RDWAIT) || (s == ST_WDATA) || (s == ST_WSTB);
  endfunction

  function automatic logic addr_phase(input seq_st_t s);
    return (s == ST_ADDR) || (s == ST_SYNC);
  endfunction

  function automatic logic data_phase(input seq_st_t s);
    return (s == ST_WDATA) || (s == ST_WSTB);
  endfunction
endpackage

// File: rtl/dmam_word_buf.sv
`timescale 1ns/1ps
module dmam_word_buf #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  localparam int IDX_W = $clog2(DEPTH)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_we,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [W-1:0]     a_data,
  input  logic             b_we,
  input  logic [IDX_W-1:0] b_idx,
  input  logic [W-1:0]     b_data,
  input  logic [IDX_W-1:0] r0_idx,
  output logic [W-1:0]     r0_data,
  input  logic [IDX_W-1:0] r1_idx,
  output logic [W-1:0]     r1_data
);
  logic [DEPTH-1:0][W-1:0] slots;

  // sequencer store wins over a local write to the same slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                   q <= '0;
      else if (a_we && (a_idx == IDX_W'(g)))        q <= a_data;
      else if (b_we && (b_idx == IDX_W'(g)))        q <= b_data;
    end
    assign slots[g] = q;
  end

  assign r0_data = slots[r0_idx];
  assign r1_data = slots[r1_idx];
endmodule

// File: rtl/dmam_xfer_ctr.sv
`timescale 1ns/1ps
module dmam_xfer_ctr import dmam_pkg::*; #(
  parameter int CNT_W = 8,
  parameter int DEPTH = 8,
  localparam int SLOT_W = $clog2(DEPTH)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [CNT_W-1:0]  load_words,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  words_left,
  output logic [SLOT_W-1:0] slot,
  output logic              last_word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr       <= '0;
      words_left <= '0;
      slot       <= '0;
    end else if (load) begin
      addr       <= load_addr;
      words_left <= load_words;
      slot       <= '0;
    end else if (step) begin
      addr       <= next_word_addr(addr);
      words_left <= words_left - CNT_W'(1);
      slot       <= SLOT_W'(next_slot(int'(slot), DEPTH));
    end
  end

  assign last_word = (words_left == CNT_W'(1));

  // R8: a word is never retired with nothing left to move
  a_r8_no_step_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (words_left != '0));
endmodule

// File: rtl/dmam_reply_timer.sv
`timescale 1ns/1ps
module dmam_reply_timer #(
  parameter int LIMIT = 1000
)(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!en)        cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + CW'(1);
  end

  assign expire = en && (cnt == TOP);

  // R9: the wait counter never passes its limit
  a_r9_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TOP);
endmodule

// File: rtl/dmam_seq.sv
`timescale 1ns/1ps
module dmam_seq import dmam_pkg::*; (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    go,
  input  logic    go_write,
  input  logic    words_zero,
  input  logic    last_word,
  input  logic    bus_grant,
  input  logic    bus_reply,
  input  logic    expire,
  output seq_st_t state,
  output logic    load,
  output logic    step,
  output logic    store_en,
  output logic    timer_en,
  output logic    is_write,
  output logic    bus_err,
  output logic    busy,
  output logic    xfer_done
);
  seq_st_t nxt;
  logic    err_hit;

  assign load     = (state == ST_IDLE) && go && !words_zero;
  assign timer_en = waits_reply(state);
  assign err_hit  = timer_en && !bus_reply && expire;
  assign store_en = (state == ST_RDWAIT) && bus_reply;
  assign step     = (state == ST_CLR) && !bus_err;
  assign xfer_done = step && last_word;
  assign busy     = (state != ST_IDLE);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (load) nxt = ST_REQ;
      ST_REQ:    if (bus_grant) nxt = ST_GACK;
      ST_GACK:   nxt = ST_ADDR;
      ST_ADDR:   nxt = ST_SYNC;
      ST_SYNC:   nxt = is_write ? ST_WDATA : ST_RDWAIT;
      ST_WDATA:  nxt = ST_WSTB;
      ST_RDWAIT,
      ST_WSTB:   if (bus_reply || expire) nxt = ST_CLR;
      ST_CLR:    nxt = (bus_err || last_word) ? ST_IDLE : ST_REQ;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      is_write <= 1'b0;
      bus_err  <= 1'b0;
    end else begin
      state <= nxt;
      if (load) begin
        is_write <= go_write;
        bus_err  <= 1'b0;
      end else if (err_hit) begin
        bus_err  <= 1'b1;
      end
    end
  end

  // R3: a grant seen while requesting moves straight to acknowledge
  a_r3_grant_to_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REQ && bus_grant) |=> (state == ST_GACK));
  // R2: a zero-count start leaves the block idle
  a_r2_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && go && words_zero) |=> (state == ST_IDLE));
  // R9: an expired wait with no reply raises the error flag
  a_r9_err_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_en && expire && !bus_reply) |=> (bus_err && state == ST_CLR));
  // R9: after an error the clear step goes back to idle
  a_r9_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CLR && bus_err) |=> (state == ST_IDLE));
endmodule

// File: rtl/dma_bus_master.sv
`timescale 1ns/1ps
module dma_bus_master import dmam_pkg::*; #(
  parameter int CNT_W       = 8,
  parameter int BUF_DEPTH   = 8,
  parameter int TIMEOUT_CYC = 1000,
  localparam int SLOT_W     = $clog2(BUF_DEPTH)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_write,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [CNT_W-1:0]  go_words,
  output logic              busy,
  output logic              xfer_done,
  output logic              bus_err,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              bus_gack,
  output logic              bus_sync,
  output logic              bus_rd,
  output logic              bus_wr,
  input  logic              bus_reply,
  output logic [AD_W-1:0]   ad_out,
  output logic              ad_oe,
  input  logic [AD_W-1:0]   ad_in,
  output logic [EXT_W-1:0]  ext_addr,
  input  logic              lb_we,
  input  logic [SLOT_W-1:0] lb_widx,
  input  logic [AD_W-1:0]   lb_wdata,
  input  logic [SLOT_W-1:0] lb_ridx,
  output logic [AD_W-1:0]   lb_rdata
);
  seq_st_t             state;
  logic                load, step, store_en, timer_en, is_write, expire, last_word;
  logic [ADDR_W-1:0]   addr;
  logic [CNT_W-1:0]    words_left;
  logic [SLOT_W-1:0]   slot;
  logic [AD_W-1:0]     tx_word;

  dmam_seq u_seq (
    .clk, .rst_n, .go, .go_write,
    .words_zero (go_words == '0),
    .last_word, .bus_grant, .bus_reply, .expire,
    .state, .load, .step, .store_en, .timer_en, .is_write,
    .bus_err, .busy, .xfer_done
  );

  dmam_xfer_ctr #(.CNT_W(CNT_W), .DEPTH(BUF_DEPTH)) u_ctr (
    .clk, .rst_n, .load,
    .load_addr (go_addr),
    .load_words(go_words),
    .step, .addr, .words_left, .slot, .last_word
  );

  dmam_reply_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk, .rst_n, .en(timer_en), .expire
  );

  dmam_word_buf #(.DEPTH(BUF_DEPTH), .W(AD_W)) u_buf (
    .clk, .rst_n,
    .a_we(store_en), .a_idx(slot), .a_data(ad_in),
    .b_we(lb_we), .b_idx(lb_widx), .b_data(lb_wdata),
    .r0_idx(slot), .r0_data(tx_word),
    .r1_idx(lb_ridx), .r1_data(lb_rdata)
  );

  // bus pin decode from the sequencer state
  always_comb begin
    bus_req  = (state == ST_REQ);
    bus_gack = holds_ack(state);
    bus_sync = holds_sync(state);
    bus_rd   = (state == ST_RDWAIT);
    bus_wr   = (state == ST_WSTB);
    ad_oe    = addr_phase(state) || data_phase(state);
    ad_out   = '0;
    ext_addr = '0;
    if (addr_phase(state)) begin
      ad_out   = addr[AD_W-1:0];
      ext_addr = addr[ADDR_W-1:AD_W];
    end else if (data_phase(state)) begin
      ad_out   = tx_word;
    end
  end

  // R10: strobes are exclusive and framed by sync
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  a_r10_strobe_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> bus_sync);
  // R4: sync only rises over an address already on the lines
  a_r4_addr_before_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_sync) |-> ($past(ad_oe) && ad_oe));
  // R3: request and acknowledge never overlap
  a_r3_req_ack_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_gack));
  // R7: release of the acknowledge leaves the bus quiet
  a_r7_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_gack) |-> (!bus_sync && !ad_oe && !bus_req && !bus_rd && !bus_wr));
  // R8: with no words left the block never requests
  a_r8_stop_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (words_left == '0) |-> !bus_req);
  // R6: write strobe only follows a data-present cycle or itself
  a_r6_data_leads: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr) |-> ($past(ad_oe) && $past(bus_sync) && ad_oe));
endmodule

// File: tb/dma_bus_master_test.sv
`timescale 1ns/1ps
module dma_bus_master_test;
  localparam int CNT_W = 5;
  localparam int DEPTH = 8;
  localparam int TMO   = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0, go_write = 1'b0;
  logic [21:0] go_addr = '0;
  logic [CNT_W-1:0] go_words = '0;
  logic        busy, xfer_done, bus_err;
  logic        bus_req, bus_gack, bus_sync, bus_rd, bus_wr, ad_oe;
  logic        bus_grant = 1'b0, bus_reply = 1'b0;
  logic [15:0] ad_out, ad_in = '0;
  logic [5:0]  ext_addr;
  logic        lb_we = 1'b0;
  logic [2:0]  lb_widx = '0, lb_ridx = '0;
  logic [15:0] lb_wdata = '0, lb_rdata;

  dma_bus_master #(.CNT_W(CNT_W), .BUF_DEPTH(DEPTH), .TIMEOUT_CYC(TMO)) uut (
    .clk, .rst_n, .go, .go_write, .go_addr, .go_words, .busy, .xfer_done, .bus_err,
    .bus_req, .bus_grant, .bus_gack, .bus_sync, .bus_rd, .bus_wr, .bus_reply,
    .ad_out, .ad_oe, .ad_in, .ext_addr,
    .lb_we, .lb_widx, .lb_wdata, .lb_ridx, .lb_rdata
  );

  initial forever #5 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mem_init(input int i);
    return 16'(i * 16'h0137) ^ 16'hA55A;
  endfunction

  // slave / arbiter model configuration
  logic [15:0] mem [256];
  int          glat = 0, rdly = 0, run_id = 0;
  bit          dead = 0;
  logic [21:0] cfg_base = '0;
  int          words_seen = 0, done_seen = 0;

  initial begin : slave
    int gcnt, rcnt, slen, wk, seen_run;
    bit p_oe, p_sync, p_gack, p_strobe, g_just;
    logic [7:0]  cur_idx;
    logic [21:0] ea;
    gcnt = 0; rcnt = 0; slen = 0; wk = 0; seen_run = -1;
    p_oe = 0; p_sync = 0; p_gack = 0; p_strobe = 0; g_just = 0; cur_idx = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (g_just) begin
          chk(!bus_req && bus_gack, "R3 ack follows grant", {bus_req, bus_gack}, 2'b01);
          g_just = 0;
        end
        if (bus_gack) begin
          bus_grant = 0; gcnt = 0;
        end else if (bus_req && !bus_grant) begin
          if (gcnt >= glat) begin bus_grant = 1; g_just = 1; end
          else gcnt++;
        end
        if (bus_sync && !p_sync) begin
          if (seen_run != run_id) begin seen_run = run_id; wk = 0; end
          ea = cfg_base + 22'(2 * wk);
          chk({ext_addr, ad_out} == ea, "R4 R8 word address", {ext_addr, ad_out}, ea);
          chk(p_oe && ad_oe && bus_gack, "R4 address ahead of sync", {p_oe, ad_oe, bus_gack}, 3'b111);
          cur_idx = ad_out[8:1];
          wk++; words_seen++;
        end
        if (bus_rd || bus_wr) begin
          chk(!(bus_rd && bus_wr) && bus_sync, "R10 strobe framing", {bus_rd, bus_wr, bus_sync}, 3'b001);
          if (bus_wr && !p_strobe)
            chk(p_oe && p_sync && ad_oe, "R6 data leads write strobe", {p_oe, p_sync, ad_oe}, 3'b111);
          slen++;
          if (!bus_reply && !dead) begin
            if (rcnt >= rdly) begin
              bus_reply = 1;
              if (bus_wr) mem[cur_idx] = ad_out;
              else        ad_in = mem[cur_idx];
            end else rcnt++;
          end
        end else begin
          if (p_strobe)
            chk(slen == (dead ? TMO : rdly + 1), "R5 R6 R9 strobe length", slen, dead ? TMO : rdly + 1);
          slen = 0; rcnt = 0; bus_reply = 0;
        end
        if (p_gack && !bus_gack)
          chk(!bus_sync && !ad_oe && !bus_rd && !bus_wr && !bus_req, "R7 clear cycle quiet",
              {bus_sync, ad_oe, bus_rd, bus_wr, bus_req}, 0);
        if (xfer_done) done_seen++;
      end
      p_oe = ad_oe; p_sync = bus_sync; p_gack = bus_gack; p_strobe = bus_rd || bus_wr;
    end
  end

  task automatic mem_reset();
    for (int i = 0; i < 256; i++) mem[i] = mem_init(i);
  endtask

  function automatic logic [15:0] wpat(input int s, input int r);
    return 16'h5A00 + 16'(s * 16'h0111) + 16'(r);
  endfunction

  task automatic run(input bit wr, input logic [21:0] base, input int n,
                     input int gl, input int rd, input bit extra);
    int w0, d0, guard, k;
    logic [21:0] a;
    glat = gl; rdly = rd; cfg_base = base; run_id++;
    mem_reset();
    if (wr) begin
      for (int s = 0; s < DEPTH; s++) begin
        @(negedge clk); lb_we = 1; lb_widx = 3'(s); lb_wdata = wpat(s, run_id);
      end
      @(negedge clk); lb_we = 0;
      for (int s = 0; s < DEPTH; s++) begin
        lb_ridx = 3'(s); #1;
        chk(lb_rdata == wpat(s, run_id), "R11 local slot readback", lb_rdata, wpat(s, run_id));
      end
    end
    w0 = words_seen; d0 = done_seen;
    @(negedge clk); go = 1; go_write = wr; go_addr = base; go_words = CNT_W'(n);
    @(negedge clk); go = 0;
    chk(busy && !bus_err, "R2 R9 start accepted, error cleared", {busy, bus_err}, 2'b10);
    if (extra) begin
      repeat (2) @(negedge clk);
      go = 1; go_write = !wr; go_addr = 22'h003000; go_words = 5'd9;
      @(negedge clk); go = 0;
    end
    guard = 0;
    while (busy && guard < 5000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
    chk(words_seen - w0 == n, "R8 R2 words moved", words_seen - w0, n);
    chk(done_seen - d0 == 1, "R8 done pulses", done_seen - d0, 1);
    chk(!bus_err && !bus_req && !busy, "R8 quiet after last word", {bus_err, bus_req, busy}, 0);
    if (wr) begin
      for (int j = 0; j < n; j++) begin
        a = base + 22'(2 * j);
        chk(mem[a[8:1]] == wpat(j % DEPTH, run_id), "R6 memory word written",
            mem[a[8:1]], wpat(j % DEPTH, run_id));
      end
    end else begin
      for (int s = 0; s < DEPTH && s < n; s++) begin
        k = s + DEPTH * ((n - 1 - s) / DEPTH);
        a = base + 22'(2 * k);
        lb_ridx = 3'(s); #1;
        chk(lb_rdata == mem_init(int'(a[8:1])), "R5 buffer slot after read",
            lb_rdata, mem_init(int'(a[8:1])));
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end

  initial begin : main
    int w0, d0, guard;
    repeat (3) @(negedge clk);
    chk({bus_req, bus_gack, bus_sync, bus_rd, bus_wr, ad_oe, busy, bus_err} == 0,
        "R1 outputs idle in reset", {bus_req, bus_gack, bus_sync, bus_rd, bus_wr, ad_oe, busy, bus_err}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk({bus_req, bus_gack, bus_sync, bus_rd, bus_wr, ad_oe, busy, bus_err} == 0,
        "R1 outputs idle after reset", {bus_req, bus_gack, bus_sync, bus_rd, bus_wr, ad_oe, busy, bus_err}, 0);

    // R2: zero count start is ignored
    @(negedge clk); go = 1; go_addr = 22'h000100; go_words = '0;
    @(negedge clk); go = 0;
    repeat (2) @(negedge clk);
    chk(!busy && !bus_req, "R2 zero count ignored", {busy, bus_req}, 0);

    // timing sweep, both directions
    for (int gl = 0; gl < 3; gl++)
      for (int rd = 0; rd < 4; rd++) begin
        run(0, 22'h000400 + 22'(gl * 64 + rd * 16), 3, gl, rd, 0);
        run(1, 22'h000800 + 22'(gl * 64 + rd * 16), 3, gl, rd, 0);
      end

    // address carry, buffer wrap, address-space wrap
    run(0, 22'h00FFFC, 4, 1, 1, 0);
    run(0, 22'h2A0040, 10, 2, 3, 0);
    run(1, 22'h01FFFA, 9, 1, 2, 0);
    run(0, 22'h3FFFFE, 2, 0, 0, 0);
    run(1, 22'h155550, 8, 3, 1, 0);
    run(0, 22'h000020, 1, 0, 0, 0);

    // R2: start while busy ignored
    run(0, 22'h000600, 4, 1, 1, 1);

    // R9: dead slave
    dead = 1; glat = 0; cfg_base = 22'h000A00; run_id++;
    w0 = words_seen; d0 = done_seen;
    @(negedge clk); go = 1; go_write = 0; go_addr = 22'h000A00; go_words = 5'd3;
    @(negedge clk); go = 0;
    guard = 0;
    while (busy && guard < 500) begin @(negedge clk); guard++; end
    repeat (4) @(negedge clk);
    chk(bus_err, "R9 error flag raised", bus_err, 1);
    chk(words_seen - w0 == 1, "R9 no further words", words_seen - w0, 1);
    chk(done_seen - d0 == 0, "R9 no done on error", done_seen - d0, 0);
    chk(!bus_req && !busy, "R9 no request after error", {bus_req, busy}, 0);
    dead = 0;
    run(1, 22'h000C00, 2, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end
endmodule